// File: doc/BRIEF.md
# Register-Mapped Asynchronous Serial Port

This block is an asynchronous serial port that a small processor drives through five byte-wide registers on a simple read/write bus. It sends and receives frames of one start bit, eight data bits (least significant bit first) and one stop bit, with no parity. The line idles high. A fixed clock divider produces a tick at sixteen times the bit rate, and the transmitter and the receiver both count these ticks. At the default divide value a 2 MHz clock gives 4800 baud.

Software uses the port through side effects. Writing the data register hands a byte to the transmitter. Reading the data register takes the received byte. The status flags follow those accesses and the events on the line. The single level interrupt output is the AND of the four upper enable bits in control 2 with the four upper status bits.

The transmitter is a state machine with the states TX_IDLE, TX_START, TX_DATA and TX_STOP. It moves from TX_IDLE to TX_START on a tick when a byte is pending and transmit is enabled. Each of the other states lasts one bit time. TX_DATA repeats eight times before it goes to TX_STOP, and TX_STOP returns to TX_IDLE. The receiver uses the states RX_IDLE, RX_START, RX_DATA and RX_STOP. It moves from RX_IDLE to RX_START on a high-to-low edge seen on ticks. In RX_START the start bit is checked at mid-bit: a low line goes on to RX_DATA, and a high line goes back to RX_IDLE. RX_DATA takes eight mid-bit samples and then goes to RX_STOP. RX_STOP samples the stop bit and returns to RX_IDLE. Clearing the receive enable forces the receiver to RX_IDLE.

Top module: `ser_port`

## Requirements
- R1: After reset the status register (offset 3) reads 0xC0, control 2 (offset 2) reads 0x00, the interrupt is low and the transmit line is high.
- R2: Offsets 0 (baud select) and 1 (control 1) read 0. Writes to offsets 0, 1 and 3 change no readable register and no flag.
- R3: Control 2 at offset 2 stores the written byte and reads it back. Bit 2 enables the receiver and bit 3 enables the transmitter.
- R4: With transmit enabled, a written byte is sent as a low start bit, eight data bits LSB first and a high stop bit. Each bit lasts OVS*CLK_DIV clocks.
- R5: A data write (offset 4) clears status bit 7 (transmit empty) and status bit 6 (transmit complete). Both flags are set again when the stop bit has been sent.
- R6: A data write while status bit 7 is clear is ignored. The frame in progress and the flags are unaffected, and no second frame follows.
- R7: While control 2 bit 3 is clear, a written byte is held and the line stays high. Setting bit 3 then sends the held byte.
- R8: When a frame has been received, status bit 5 (receive full) is set. A read of offset 4 returns the byte and clears bit 5.
- R9: A low pulse on the receive line that is shorter than half a bit is rejected at the mid-bit check and sets no flag.
- R10: If a frame completes while bit 5 is set, status bit 3 (overrun) is set and the earlier byte is kept. A data read clears bit 3.
- R11: A stop bit sampled low sets status bit 1 (framing error), which a data read clears. The receiver then waits for the line to go high before it accepts a new start.
- R12: The interrupt output equals the OR of (control 2 AND status AND 0xF0). Bits 7, 6, 5 and 4 of control 2 enable the status bits at the same positions.
- R13: While control 2 bit 2 is clear, frames on the receive line set no status flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one clock per access |
| bus_rd | input | 1 | Read strobe, one clock per access; a data read has side effects |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| line_rx | input | 1 | Serial receive line, idle high |
| line_tx | output | 1 | Serial transmit line, idle high |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the port with CLK_DIV = 2 and OVS = 16, so one bit lasts 32 clocks and a full frame lasts 320 clocks. With bits this short, the bench can queue back-to-back frames for the overrun case and hold a byte behind a disabled transmitter. It can also send a deliberately short start glitch and a frame with a low stop bit, all within a short run. With sixteen ticks per bit, the glitch test is meaningful: the mid-bit start check falls eight ticks in, well after a four-clock pulse has ended.

// File: rtl/ser_port_pkg.sv
package ser_port_pkg;

    localparam int unsigned ADDR_W = 3;
    localparam int unsigned BYTE_W = 8;

    localparam logic [ADDR_W-1:0] OFS_BAUD   = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_CTRL1  = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_CTRL2  = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_DATA   = 3'd4;

    localparam int unsigned C2_RX_EN = 2;
    localparam int unsigned C2_TX_EN = 3;

    localparam logic [BYTE_W-1:0] IRQ_SRC_MASK = 8'hF0;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_STOP
    } tx_state_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_t;

endpackage

// File: rtl/ser_tick_gen.sv
module ser_tick_gen #(
    parameter int unsigned CLK_DIV = 26
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (CLK_DIV <= 1) begin : g_pass
            assign tick = rst_n;
        end else begin : g_count
            localparam int unsigned CW = $clog2(CLK_DIV);
            localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);
            logic [CW-1:0] cnt_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (cnt_q == LAST) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign tick = (cnt_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/ser_tx.sv
module ser_tx
    import ser_port_pkg::*;
#(
    parameter int unsigned OVS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  logic [BYTE_W-1:0] data,
    output logic              line,
    output logic              done
);
    localparam int unsigned CW = $clog2(OVS);
    localparam logic [CW-1:0] CNT_LAST = CW'(OVS - 1);
    localparam int unsigned BW = $clog2(BYTE_W);
    localparam logic [BW-1:0] BIT_LAST = BW'(BYTE_W - 1);

    tx_state_t         state_q;
    logic [CW-1:0]     cnt_q;
    logic [BW-1:0]     bit_q;
    logic [BYTE_W-1:0] shreg_q;
    logic              bit_end;

    assign bit_end = tick && (cnt_q == CNT_LAST);

    // state register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            cnt_q   <= '0;
            bit_q   <= '0;
            shreg_q <= '0;
        end else begin
            unique case (state_q)
                TX_IDLE: begin
                    if (start && tick) begin
                        state_q <= TX_START;
                        cnt_q   <= '0;
                        shreg_q <= data;
                    end
                end
                TX_START: begin
                    if (bit_end) begin
                        state_q <= TX_DATA;
                        bit_q   <= '0;
                    end
                end
                TX_DATA: begin
                    if (bit_end) begin
                        shreg_q <= shreg_q >> 1;
                        if (bit_q == BIT_LAST) begin
                            state_q <= TX_STOP;
                        end else begin
                            bit_q <= bit_q + 1'b1;
                        end
                    end
                end
                TX_STOP: begin
                    if (bit_end) begin
                        state_q <= TX_IDLE;
                    end
                end
            endcase
            if (state_q != TX_IDLE && tick) begin
                cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        line = 1'b1;
        done = 1'b0;
        unique case (state_q)
            TX_IDLE:  line = 1'b1;
            TX_START: line = 1'b0;
            TX_DATA:  line = shreg_q[0];
            TX_STOP: begin
                line = 1'b1;
                done = bit_end;
            end
        endcase
    end

    assert_bit_index_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_DATA && bit_end && bit_q == BIT_LAST) |=> (state_q == TX_STOP));

    assert_idle_start_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_IDLE && !tick) |=> (state_q == TX_IDLE));
endmodule

// File: rtl/ser_rx.sv
module ser_rx
    import ser_port_pkg::*;
#(
    parameter int unsigned OVS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              en,
    input  logic              line,
    output logic              done,
    output logic              stop_ok,
    output logic [BYTE_W-1:0] data
);
    localparam int unsigned CW = $clog2(OVS);
    localparam logic [CW-1:0] CNT_LAST = CW'(OVS - 1);
    localparam logic [CW-1:0] CNT_MID  = CW'(OVS / 2 - 1);
    localparam int unsigned BW = $clog2(BYTE_W);
    localparam logic [BW-1:0] BIT_LAST = BW'(BYTE_W - 1);

    rx_state_t         state_q;
    logic [CW-1:0]     cnt_q;
    logic [BW-1:0]     bit_q;
    logic [BYTE_W-1:0] shreg_q;
    logic [1:0]        sync_q;
    logic              prev_q;
    logic              rx_s;
    logic              mid_hit;
    logic              end_hit;

    assign rx_s    = sync_q[1];
    assign mid_hit = tick && (cnt_q == CNT_MID);
    assign end_hit = tick && (cnt_q == CNT_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], line};
            if (tick) prev_q <= rx_s;
        end
    end

    // state register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
            bit_q   <= '0;
            shreg_q <= '0;
        end else if (!en) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                RX_IDLE: begin
                    if (tick && prev_q && !rx_s) begin
                        state_q <= RX_START;
                        cnt_q   <= '0;
                    end
                end
                RX_START: begin
                    if (mid_hit) begin
                        cnt_q <= '0;
                        bit_q <= '0;
                        state_q <= rx_s ? RX_IDLE : RX_DATA;
                    end else if (tick) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (end_hit) begin
                        cnt_q   <= '0;
                        shreg_q <= {rx_s, shreg_q[BYTE_W-1:1]};
                        if (bit_q == BIT_LAST) begin
                            state_q <= RX_STOP;
                        end else begin
                            bit_q <= bit_q + 1'b1;
                        end
                    end else if (tick) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (end_hit) begin
                        cnt_q   <= '0;
                        state_q <= RX_IDLE;
                    end else if (tick) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        done    = 1'b0;
        stop_ok = 1'b1;
        unique case (state_q)
            RX_IDLE, RX_START, RX_DATA: done = 1'b0;
            RX_STOP: begin
                done    = en && end_hit;
                stop_ok = rx_s;
            end
        endcase
    end

    assign data = shreg_q;

    assert_false_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && state_q == RX_START && mid_hit && rx_s) |=> (state_q == RX_IDLE));

    assert_disabled_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!en) |=> (state_q == RX_IDLE));
endmodule

// File: rtl/ser_port.sv
module ser_port
    import ser_port_pkg::*;
#(
    parameter int unsigned CLK_DIV = 26,
    parameter int unsigned OVS     = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       line_rx,
    output logic       line_tx,
    output logic       irq
);
    logic              tick;
    logic [BYTE_W-1:0] ctl2_q;
    logic [BYTE_W-1:0] hold_q;
    logic [BYTE_W-1:0] rx_data_q;
    logic              tdre_q, tc_q, rdrf_q, ovr_q, fe_q;
    logic [BYTE_W-1:0] status;
    logic              tx_done, rx_done, rx_stop_ok;
    logic [BYTE_W-1:0] rx_byte;
    logic              wr_data, rd_data, wr_ctl2;

    assign wr_data = bus_wr && (bus_addr == OFS_DATA);
    assign rd_data = bus_rd && (bus_addr == OFS_DATA);
    assign wr_ctl2 = bus_wr && (bus_addr == OFS_CTRL2);

    ser_tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    ser_tx #(.OVS(OVS)) u_tx (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .start(!tdre_q && ctl2_q[C2_TX_EN]),
        .data (hold_q),
        .line (line_tx),
        .done (tx_done)
    );

    ser_rx #(.OVS(OVS)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .en     (ctl2_q[C2_RX_EN]),
        .line   (line_rx),
        .done   (rx_done),
        .stop_ok(rx_stop_ok),
        .data   (rx_byte)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl2_q    <= '0;
            hold_q    <= '0;
            rx_data_q <= '0;
            tdre_q    <= 1'b1;
            tc_q      <= 1'b1;
            rdrf_q    <= 1'b0;
            ovr_q     <= 1'b0;
            fe_q      <= 1'b0;
        end else begin
            if (wr_ctl2) ctl2_q <= bus_wdata;

            if (wr_data && tdre_q) begin
                hold_q <= bus_wdata;
                tdre_q <= 1'b0;
                tc_q   <= 1'b0;
            end else if (tx_done) begin
                tdre_q <= 1'b1;
                tc_q   <= 1'b1;
            end

            if (rd_data) begin
                rdrf_q <= 1'b0;
                ovr_q  <= 1'b0;
                fe_q   <= 1'b0;
            end
            if (rx_done) begin
                if (rdrf_q && !rd_data) begin
                    ovr_q <= 1'b1;
                end else begin
                    rx_data_q <= rx_byte;
                    rdrf_q    <= 1'b1;
                end
                if (!rx_stop_ok) fe_q <= 1'b1;
            end
        end
    end

    assign status = {tdre_q, tc_q, rdrf_q, 1'b0, ovr_q, 1'b0, fe_q, 1'b0};

    always_comb begin
        unique case (bus_addr)
            OFS_CTRL2:  bus_rdata = ctl2_q;
            OFS_STATUS: bus_rdata = status;
            OFS_DATA:   bus_rdata = rx_data_q;
            default:    bus_rdata = '0;
        endcase
    end

    assign irq = |(ctl2_q & status & IRQ_SRC_MASK);

    assert_tx_flags_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && tdre_q) |=> (!tdre_q && !tc_q));

    assert_busy_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && !tdre_q) |=> $stable(hold_q));

    assert_read_clears_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !rx_done) |=> !rdrf_q);

    assert_overrun_keeps_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rdrf_q && !rd_data) |=> ($stable(rx_data_q) && ovr_q));

    assert_irq_masked_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl2 && bus_wdata[7:4] == 4'h0) |=> !irq);
endmodule

// File: tb/ser_port_tb_top.sv
`timescale 1ns/1ps
module ser_port_tb_top;
    localparam int unsigned CLK_DIV = 2;
    localparam int unsigned OVS     = 16;
    localparam int unsigned BITCLK  = CLK_DIV * OVS;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       line_rx = 1'b1;
    logic       line_tx;
    logic       irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    ser_port #(.CLK_DIV(CLK_DIV), .OVS(OVS)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .line_rx(line_rx), .line_tx(line_tx), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic capture_tx(output logic [7:0] b, output logic ok);
        int waited = 0;
        b = '0; ok = 1'b1;
        while (line_tx === 1'b1 && waited < 4000) begin
            @(negedge clk); waited++;
        end
        if (waited >= 4000) begin ok = 1'b0; return; end
        repeat (BITCLK/2) @(negedge clk);
        if (line_tx !== 1'b0) ok = 1'b0;
        for (int i = 0; i < 8; i++) begin
            repeat (BITCLK) @(negedge clk);
            b[i] = line_tx;
        end
        repeat (BITCLK) @(negedge clk);
        if (line_tx !== 1'b1) ok = 1'b0;
    endtask

    task automatic quiet_clocks(input int n, output int lows);
        lows = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (line_tx !== 1'b1) lows++;
        end
    endtask

    task automatic send_rx(input logic [7:0] b, input logic stop_lvl);
        @(negedge clk);
        line_rx = 1'b0;
        repeat (BITCLK) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            line_rx = b[i];
            repeat (BITCLK) @(negedge clk);
        end
        line_rx = stop_lvl;
        repeat (BITCLK) @(negedge clk);
        line_rx = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        reg_rd(3'd3, d); check("R1 status", d, 8'hC0);
        reg_rd(3'd2, d); check("R1 ctl2", d, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
        check("R1 line_tx", {7'd0, line_tx}, 8'h01);
    endtask

    task automatic t_regs;
        logic [7:0] d;
        reg_wr(3'd0, 8'hFF); reg_wr(3'd1, 8'hFF); reg_wr(3'd3, 8'h3F);
        reg_rd(3'd0, d); check("R2 baud reads 0", d, 8'h00);
        reg_rd(3'd1, d); check("R2 ctl1 reads 0", d, 8'h00);
        reg_rd(3'd3, d); check("R2 status write ignored", d, 8'hC0);
        reg_wr(3'd2, 8'h5A);
        reg_rd(3'd2, d); check("R3 ctl2 readback", d, 8'h5A);
        reg_wr(3'd2, 8'h00);
    endtask

    task automatic t_tx_basic;
        logic [7:0] d, b; logic ok;
        reg_wr(3'd2, 8'h08);
        reg_wr(3'd4, 8'hA5);
        reg_rd(3'd3, d); check("R5 flags cleared", d, 8'h00);
        capture_tx(b, ok);
        check("R4 frame shape", {7'd0, ok}, 8'h01);
        check("R4 frame byte", b, 8'hA5);
        repeat (BITCLK) @(negedge clk);
        reg_rd(3'd3, d); check("R5 flags set after stop", d, 8'hC0);
    endtask

    task automatic t_tx_busy;
        logic [7:0] b; logic ok; int lows;
        reg_wr(3'd4, 8'hC3);
        reg_wr(3'd4, 8'h3C);
        capture_tx(b, ok);
        check("R6 first frame kept", b, 8'hC3);
        quiet_clocks(12 * BITCLK, lows);
        check("R6 no second frame", lows[7:0], 8'h00);
    endtask

    task automatic t_tx_hold;
        logic [7:0] d, b; logic ok; int lows;
        reg_wr(3'd2, 8'h00);
        reg_wr(3'd4, 8'h5A);
        quiet_clocks(12 * BITCLK, lows);
        check("R7 line idle while disabled", lows[7:0], 8'h00);
        reg_rd(3'd3, d); check("R7 byte pending", d, 8'h00);
        reg_wr(3'd2, 8'h08);
        capture_tx(b, ok);
        check("R7 held byte sent", b, 8'h5A);
        repeat (BITCLK) @(negedge clk);
        reg_wr(3'd2, 8'h00);
    endtask

    task automatic t_rx_basic;
        logic [7:0] d;
        reg_wr(3'd2, 8'h04);
        send_rx(8'h96, 1'b1);
        reg_rd(3'd3, d); check("R8 full set", d, 8'hE0);
        reg_rd(3'd4, d); check("R8 byte", d, 8'h96);
        reg_rd(3'd3, d); check("R8 full cleared", d, 8'hC0);
    endtask

    task automatic t_glitch;
        logic [7:0] d;
        @(negedge clk); line_rx = 1'b0;
        repeat (4) @(negedge clk); line_rx = 1'b1;
        repeat (12 * BITCLK) @(negedge clk);
        reg_rd(3'd3, d); check("R9 glitch rejected", d, 8'hC0);
        send_rx(8'h3B, 1'b1);
        reg_rd(3'd4, d); check("R9 next frame clean", d, 8'h3B);
    endtask

    task automatic t_overrun;
        logic [7:0] d;
        send_rx(8'h11, 1'b1);
        send_rx(8'h22, 1'b1);
        reg_rd(3'd3, d); check("R10 overrun flag", d, 8'hE8);
        reg_rd(3'd4, d); check("R10 old byte kept", d, 8'h11);
        reg_rd(3'd3, d); check("R10 cleared by read", d, 8'hC0);
    endtask

    task automatic t_framing;
        logic [7:0] d;
        send_rx(8'h7E, 1'b0);
        reg_rd(3'd3, d); check("R11 framing flag", d, 8'hE2);
        reg_rd(3'd4, d); check("R11 byte", d, 8'h7E);
        reg_rd(3'd3, d); check("R11 cleared by read", d, 8'hC0);
    endtask

    task automatic t_irq;
        logic [7:0] d;
        reg_wr(3'd2, 8'h80); check("R12 irq on empty", {7'd0, irq}, 8'h01);
        reg_wr(3'd2, 8'h40); check("R12 irq on complete", {7'd0, irq}, 8'h01);
        reg_wr(3'd2, 8'h10); check("R12 idle source clear", {7'd0, irq}, 8'h00);
        reg_wr(3'd2, 8'h24); check("R12 no rx irq yet", {7'd0, irq}, 8'h00);
        send_rx(8'h42, 1'b1);
        check("R12 irq on full", {7'd0, irq}, 8'h01);
        reg_rd(3'd4, d);
        check("R12 irq drops on read", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_rx_off;
        logic [7:0] d;
        reg_wr(3'd2, 8'h00);
        send_rx(8'h55, 1'b1);
        reg_rd(3'd3, d); check("R13 rx disabled", d, 8'hC0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_regs();
        t_tx_basic();
        t_tx_busy();
        t_tx_hold();
        t_rx_basic();
        t_glitch();
        t_overrun();
        t_framing();
        t_irq();
        t_rx_off();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule